// File: doc/BRIEF.md
# Soft Mute Attenuation Ramp

This block sits in a digital audio path. It holds a gain index that moves gradually between a programmed attenuation level and full mute, and it scales each incoming sample by that index. A mute request can come from a dedicated input pin or from a control bit. Either source starts a ramp from the present index down to zero. When the request is withdrawn, the index climbs back to the programmed level at the same rate.

Timing is counted in frames. The index moves by one unit once every fixed number of frame strobes, four by default. A full descent from level 255 therefore takes 1020 frames. A ramp that is interrupted turns around at the index it has reached. A change to the programmed level made while no mute is active is also followed one unit at a time. Gain is linear: the output equals the sample times the index divided by 256, rounded toward zero.

Top module: `soft_mute_ramp`

## Requirements
- R1: The mute request is the OR of `mute_pin` and `mute_bit`. With a request present the target index is 0. Without one the target is `atten_level`.
- R2: While the index differs from the target, it moves by exactly one toward the target on every fourth `frame_tick`. The index never changes on a clock where `frame_tick` is low.
- R3: From index 255, a mute request reaches index 0 after exactly 1020 frame strobes. After release, the climb back to the level uses the same four frames per step.
- R4: A mute request or release that arrives part-way through a ramp reverses the ramp from its current index. The frame prescaler is not restarted.
- R5: A change of `atten_level` while no mute is requested is followed one step at a time, at the same four-frame rate. The prescaler stays at zero while the index equals the target.
- R6: `sample_out` equals `sample_in` × `gain_idx` / 256, rounded toward zero. It is combinational from the current index and sample. `sample_in` and `sample_out` are two's-complement signed values.
- R7: When `gain_idx` is 0, `sample_out` is exactly 0 for every input sample.
- R8: `ramping` is high exactly when the index differs from the target. `muted` is high exactly when a mute is requested and the index is 0.
- R9: After reset the index and the prescaler are both 0.
- R10: A frame strobe that completes a step on the same clock as a change of mute request moves the index toward the new target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_tick | input | 1 | One-clock strobe, once per audio frame |
| mute_pin | input | 1 | External mute request |
| mute_bit | input | 1 | Register mute request |
| atten_level | input | 8 | Programmed attenuation index |
| sample_in | input | 24 | Signed input sample |
| gain_idx | output | 8 | Current attenuation index |
| sample_out | output | 24 | Signed attenuated sample |
| ramping | output | 1 | Index is moving toward its target |
| muted | output | 1 | Mute requested and index at zero |

## Verification
Two events can fall on the same clock edge: a step-completing frame strobe and a change of mute request. In that case the step direction must follow the new target, not the old one. The bench provokes this case by first letting the prescaler reach three strobes while the index climbs toward a raised level. It then raises the mute pin on the very clock that carries the fourth strobe. It judges the outcome by requiring the index to fall by one rather than rise, and then requires four further strobes after release to bring it back.

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp #(
  parameter int SAMPLE_W    = 24,
  parameter int LEVEL_W     = 8,
  parameter int STEP_FRAMES = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frame_tick,
  input  logic                       mute_pin,
  input  logic                       mute_bit,
  input  logic [LEVEL_W-1:0]         atten_level,
  input  logic signed [SAMPLE_W-1:0] sample_in,
  output logic [LEVEL_W-1:0]         gain_idx,
  output logic signed [SAMPLE_W-1:0] sample_out,
  output logic                       ramping,
  output logic                       muted
);
  localparam int PRE_W  = (STEP_FRAMES > 1) ? $clog2(STEP_FRAMES) : 1;
  localparam int PROD_W = SAMPLE_W + LEVEL_W + 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(STEP_FRAMES - 1);

  logic               mute_req;
  logic [LEVEL_W-1:0] target;
  logic [LEVEL_W-1:0] idx;
  logic [PRE_W-1:0]   pre;
  logic               step_due;

  assign mute_req = mute_pin | mute_bit;
  assign target   = mute_req ? '0 : atten_level;
  assign ramping  = (idx != target);
  assign muted    = mute_req && (idx == '0);
  assign step_due = frame_tick && ramping && (pre == PRE_LAST);
  assign gain_idx = idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
      pre <= '0;
    end else if (!ramping) begin
      pre <= '0;
    end else if (frame_tick) begin
      if (step_due) begin
        pre <= '0;
        idx <= (idx < target) ? idx + 1'b1 : idx - 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  logic signed [PROD_W-1:0] s_ext, g_ext, prod, biased;

  assign s_ext  = PROD_W'(sample_in);
  assign g_ext  = signed'(PROD_W'(idx));
  assign prod   = s_ext * g_ext;
  assign biased = prod + (prod[PROD_W-1] ? PROD_W'((1 << LEVEL_W) - 1) : '0);
  assign sample_out = SAMPLE_W'(biased >>> LEVEL_W);

  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (idx == $past(idx)) || (idx == $past(idx) + 1'b1) || (idx == $past(idx) - 1'b1));

  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(idx));

  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ramping |=> $stable(idx));

  a_r10_mute_moves_down: assert property (@(posedge clk) disable iff (!rst_n)
    mute_req |=> idx <= $past(idx));

  a_r7_zero_output: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == '0) |-> (sample_out == '0));

  a_r6_no_gain_positive: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_in >= 0) |-> (sample_out >= 0 && sample_out <= sample_in));

  a_r6_no_gain_negative: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_in < 0) |-> (sample_out <= 0 && sample_out >= sample_in));
endmodule

// File: tb/soft_mute_ramp_bench.sv
module soft_mute_ramp_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_tick = 1'b0;
  logic mute_pin = 1'b0;
  logic mute_bit = 1'b0;
  logic [7:0] atten_level = 8'd255;
  logic signed [23:0] sample_in = 24'sd1000;
  logic [7:0] gain_idx;
  logic signed [23:0] sample_out;
  logic ramping, muted;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  soft_mute_ramp u_soft_mute_ramp (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
    .mute_pin(mute_pin), .mute_bit(mute_bit), .atten_level(atten_level),
    .sample_in(sample_in), .gain_idx(gain_idx), .sample_out(sample_out),
    .ramping(ramping), .muted(muted)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) frame_tick = 1'b1;
      @(negedge clk) frame_tick = 1'b0;
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "index after reset", gain_idx, 0);
    chk("R7", "output at index 0", sample_out, 0);
    chk("R8", "ramping toward level", ramping, 1);
    chk("R8", "muted without request", muted, 0);
  endtask

  task automatic t_rampup;
    ticks(3);
    chk("R2", "no step before 4th strobe", gain_idx, 0);
    ticks(1);
    chk("R2", "step on 4th strobe", gain_idx, 1);
    ticks(1016);
    chk("R5", "level reached", gain_idx, 255);
    chk("R8", "ramping ends", ramping, 0);
  endtask

  task automatic t_mute_pin;
    mute_pin = 1'b1;
    sample_in = 24'sd5000;
    @(negedge clk);
    chk("R1", "pin starts ramp", ramping, 1);
    ticks(1019);
    chk("R3", "one step left", gain_idx, 1);
    chk("R8", "not yet muted", muted, 0);
    ticks(1);
    chk("R3", "full mute at 1020", gain_idx, 0);
    chk("R8", "muted flag", muted, 1);
    chk("R7", "zero output", sample_out, 0);
    ticks(8);
    chk("R3", "stays muted", gain_idx, 0);
  endtask

  task automatic t_reverse;
    mute_pin = 1'b0;
    ticks(400);
    chk("R3", "climb rate", gain_idx, 100);
    mute_bit = 1'b1;
    ticks(40);
    chk("R4", "reverse via bit", gain_idx, 90);
    chk("R1", "bit alone mutes", ramping, 1);
    mute_bit = 1'b0;
    ticks(40);
    chk("R4", "reverse again", gain_idx, 100);
    ticks(620);
    chk("R3", "back at level", gain_idx, 255);
  endtask

  task automatic t_no_tick;
    atten_level = 8'd200;
    repeat (50) @(negedge clk);
    chk("R2", "no strobe no change", gain_idx, 255);
  endtask

  task automatic t_level;
    atten_level = 8'd250;
    @(negedge clk);
    ticks(3);
    chk("R5", "level follow wait", gain_idx, 255);
    ticks(1);
    chk("R5", "level follow step", gain_idx, 254);
    ticks(16);
    chk("R5", "level follow done", gain_idx, 250);
    chk("R8", "idle after follow", ramping, 0);
  endtask

  task automatic t_gain;
    sample_in = 24'sd1000;   #1 chk("R6", "gain +1000", sample_out, 976);
    sample_in = -24'sd1000;  #1 chk("R6", "gain -1000", sample_out, -976);
    sample_in = -24'sd1;     #1 chk("R6", "toward zero -1", sample_out, 0);
    sample_in = 24'sd1;      #1 chk("R6", "toward zero +1", sample_out, 0);
    sample_in = 24'sd8388607;  #1 chk("R6", "max positive", sample_out, 8191999);
    sample_in = -24'sd8388608; #1 chk("R6", "max negative", sample_out, -8192000);
  endtask

  task automatic t_coincide;
    atten_level = 8'd252;
    @(negedge clk);
    ticks(3);
    chk("R10", "prescaler loaded", gain_idx, 250);
    @(negedge clk);
    mute_pin = 1'b1;
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
    chk("R10", "step follows new target", gain_idx, 249);
    mute_pin = 1'b0;
    ticks(3);
    chk("R10", "fresh prescale", gain_idx, 249);
    ticks(1);
    chk("R10", "step after release", gain_idx, 250);
  endtask

  initial begin
    t_reset();
    t_rampup();
    t_mute_pin();
    t_reverse();
    t_no_tick();
    t_level();
    t_gain();
    t_coincide();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule